// File: doc/BRIEF.md
# Four-channel status LED driver with per-pin function select

This block turns the status signals of an Ethernet PHY into the levels of four indicator LEDs. Each LED picks one of sixteen function codes. The codes cover link, speed, duplex, raw activity, stretched blinking on activity, link loss, a PRBS error toggle and a stretched interface-error indication. Two configuration words are written over a narrow write-only register bus. The first word selects the function of each LED. The second word holds a manual override and an output polarity for each LED.

Activity and error inputs are single-cycle pulses. A pulse reloads a stretch timer, so its effect lasts `STRETCH` cycles after the last pulse. The blink modes toggle the LED every `BLINK_DIV` cycles while their timer runs. The phase of that toggle comes from one free-running prescaler that all four LEDs share. Each LED pin is registered.

Top module: `led_mode_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 loads the function word. LED n takes its 4-bit function code from bits 4n+3..4n of that word. A write with `wr_sel`=1 loads the drive word.
- R2: Function codes 0..7 show the following: 0 link up, 1 `tx_pulse` OR `rx_pulse`, 2 `tx_pulse`, 3 `rx_pulse`, 4 and 5 constant off, 6 `speed_10m`, 7 `full_dup`. Code 0xC shows `link_lost`. Code 0xF is constant off.
- R3: Code 9 blinks on the stretched OR of TX and RX activity. Code 0xA blinks on stretched TX activity only. Code 0xB blinks on stretched RX activity only. While the selected timer runs, the LED toggles every `BLINK_DIV` cycles. When the timer is idle, the LED is off.
- R4: A pulse keeps its stretch timer active for exactly `STRETCH` cycles. A new pulse restarts the full interval.
- R5: Code 8 is on while the link is up and blinks off in phase with the blink clock while stretched activity runs.
- R6: Code 0xD inverts its level on each `prbs_err` pulse. The level starts at 0 after reset.
- R7: Code 0xE is steadily on while the `xmii_err` stretch timer runs.
- R8: In the drive word, bit 4n is the override enable of LED n and bit 4n+1 is its manual level. While the override is enabled, the function code has no effect and the LED shows the manual level.
- R9: Bit 4n+2 of the drive word is the polarity of LED n. A value of 1 passes the level through. A value of 0 inverts the final level, including an overridden one.
- R10: After reset the function word is 0 and the drive word has only the polarity bits set. All LEDs then follow the link-up input.
- R11: `led_o` is registered. A change on a status input appears one clock later. A configuration write takes effect on the second clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = function word, 1 = drive word |
| wr_data | input | 4*NUM_LED | Write data |
| link_up | input | 1 | Link established |
| speed_10m | input | 1 | Link runs at 10 Mb/s |
| full_dup | input | 1 | Full duplex |
| link_lost | input | 1 | Link-lost status |
| prbs_err | input | 1 | PRBS error pulse |
| xmii_err | input | 1 | MAC interface TX/RX error pulse |
| tx_pulse | input | 1 | Transmit activity pulse |
| rx_pulse | input | 1 | Receive activity pulse |
| led_o | output | NUM_LED | LED pin levels |

## Verification
A status input change is visible on `led_o` one clock later, and a configuration write two clocks later. The bench therefore drives on a falling edge and samples on the falling edge after the following rising edge. Stretch lengths are measured by counting high samples that start on the second falling edge after the pulse, which gives exactly `STRETCH` for a single pulse. Blink behaviour is checked by counting transitions over a 64-sample window, since the shared prescaler phase is free-running.

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl #(
  parameter int NUM_LED   = 4,
  parameter int BLINK_DIV = 12500000,
  parameter int STRETCH   = 25000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [4*NUM_LED-1:0] wr_data,
  input  logic                 link_up,
  input  logic                 speed_10m,
  input  logic                 full_dup,
  input  logic                 link_lost,
  input  logic                 prbs_err,
  input  logic                 xmii_err,
  input  logic                 tx_pulse,
  input  logic                 rx_pulse,
  output logic [NUM_LED-1:0]   led_o
);
  localparam int RW = 4 * NUM_LED;
  localparam int PW = (BLINK_DIV > 2) ? $clog2(BLINK_DIV) : 1;
  localparam int SW = $clog2(STRETCH + 1);

  function automatic logic [RW-1:0] drive_reset();
    logic [RW-1:0] d;
    d = '0;
    for (int i = 0; i < NUM_LED; i++) d[4*i+2] = 1'b1;
    return d;
  endfunction

  logic [RW-1:0]       cfg_func, cfg_drv;
  logic [PW-1:0]       pre_cnt;
  logic                blink_ph;
  logic                prbs_tgl;
  logic [3:0][SW-1:0]  st_cnt;
  logic [3:0]          st_on;
  logic [3:0]          st_trig;

  assign st_trig = {xmii_err, rx_pulse, tx_pulse, tx_pulse | rx_pulse};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_func <= '0;
      cfg_drv  <= drive_reset();
    end else if (wr_en) begin
      if (wr_sel) cfg_drv  <= wr_data;
      else        cfg_func <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      blink_ph <= 1'b0;
    end else if (pre_cnt == PW'(BLINK_DIV - 1)) begin
      pre_cnt  <= '0;
      blink_ph <= ~blink_ph;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prbs_tgl <= 1'b0;
    else if (prbs_err) prbs_tgl <= ~prbs_tgl;
  end

  for (genvar k = 0; k < 4; k++) begin : g_str
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              st_cnt[k] <= '0;
      else if (st_trig[k])     st_cnt[k] <= SW'(STRETCH);
      else if (st_cnt[k] != 0) st_cnt[k] <= st_cnt[k] - 1'b1;
    end
    assign st_on[k] = (st_cnt[k] != '0);
  end

  for (genvar i = 0; i < NUM_LED; i++) begin : g_led
    logic [3:0] mode;
    logic       hw_lvl, lvl;
    assign mode = cfg_func[4*i +: 4];

    always_comb begin
      case (mode)
        4'h0:    hw_lvl = link_up;
        4'h1:    hw_lvl = tx_pulse | rx_pulse;
        4'h2:    hw_lvl = tx_pulse;
        4'h3:    hw_lvl = rx_pulse;
        4'h6:    hw_lvl = speed_10m;
        4'h7:    hw_lvl = full_dup;
        4'h8:    hw_lvl = link_up & ~(st_on[0] & blink_ph);
        4'h9:    hw_lvl = st_on[0] & blink_ph;
        4'hA:    hw_lvl = st_on[1] & blink_ph;
        4'hB:    hw_lvl = st_on[2] & blink_ph;
        4'hC:    hw_lvl = link_lost;
        4'hD:    hw_lvl = prbs_tgl;
        4'hE:    hw_lvl = st_on[3];
        default: hw_lvl = 1'b0;
      endcase
    end

    assign lvl = cfg_drv[4*i] ? cfg_drv[4*i+1] : hw_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_o[i] <= 1'b0;
      else        led_o[i] <= cfg_drv[4*i+2] ? lvl : ~lvl;
    end
  end
endmodule

// File: rtl/led_mode_ctrl_chk.sv
module led_mode_ctrl_chk #(
  parameter int NUM_LED   = 4,
  parameter int BLINK_DIV = 4,
  parameter int STRETCH   = 8,
  parameter int PW        = 2,
  parameter int SW        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 wr_sel,
  input logic [4*NUM_LED-1:0] wr_data,
  input logic [4*NUM_LED-1:0] cfg_func,
  input logic [4*NUM_LED-1:0] cfg_drv,
  input logic [NUM_LED-1:0]   led_o,
  input logic                 prbs_err,
  input logic                 prbs_tgl,
  input logic [PW-1:0]        pre_cnt,
  input logic                 blink_ph,
  input logic                 xmii_err,
  input logic [SW-1:0]        err_cnt
);
  // R1
  func_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> cfg_func == $past(wr_data));

  // R6
  prbs_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_err |=> prbs_tgl != $past(prbs_tgl));

  // R6
  prbs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prbs_err |=> $stable(prbs_tgl));

  // R3
  blink_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt != PW'(BLINK_DIV - 1)) |=> $stable(blink_ph));

  // R4
  err_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmii_err |=> err_cnt == SW'(STRETCH));

  for (genvar i = 0; i < NUM_LED; i++) begin : g_ovr
    // R8
    override_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_drv[4*i] |=> led_o[i] == ($past(cfg_drv[4*i+1]) ~^ $past(cfg_drv[4*i+2])));
  end
endmodule

bind led_mode_ctrl led_mode_ctrl_chk #(
  .NUM_LED(NUM_LED), .BLINK_DIV(BLINK_DIV), .STRETCH(STRETCH), .PW(PW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cfg_func(cfg_func), .cfg_drv(cfg_drv), .led_o(led_o), .prbs_err(prbs_err),
  .prbs_tgl(prbs_tgl), .pre_cnt(pre_cnt), .blink_ph(blink_ph),
  .xmii_err(xmii_err), .err_cnt(st_cnt[3])
);

// File: tb/sim_led_mode_ctrl.sv
module sim_led_mode_ctrl;
  localparam int NL = 4;
  localparam int DIV = 4;
  localparam int STR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0;
  logic [15:0] wr_data = '0;
  logic link_up = 0, speed_10m = 0, full_dup = 0, link_lost = 0;
  logic prbs_err = 0, xmii_err = 0, tx_pulse = 0, rx_pulse = 0;
  logic [NL-1:0] led_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  led_mode_ctrl #(.NUM_LED(NL), .BLINK_DIV(DIV), .STRETCH(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .link_up(link_up), .speed_10m(speed_10m), .full_dup(full_dup),
    .link_lost(link_lost), .prbs_err(prbs_err), .xmii_err(xmii_err),
    .tx_pulse(tx_pulse), .rx_pulse(rx_pulse), .led_o(led_o));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [3:0] static_mode(int idx);
    if (idx < 8) return 4'(idx);
    return (idx == 8) ? 4'hC : 4'hF;
  endfunction

  function automatic logic expect_static(logic [3:0] m, logic [5:0] s);
    case (m)
      4'h0: return s[0];
      4'h1: return s[4] | s[5];
      4'h2: return s[4];
      4'h3: return s[5];
      4'h6: return s[1];
      4'h7: return s[2];
      4'hC: return s[3];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic [15:0] fw, dw;
    logic [3:0] prev;
    int tr[NL];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset defaults, link down
    check("R10 reset leds", led_o, 0);
    link_up = 1;
    @(negedge clk);
    check("R10 default follows link", led_o, 4'hF);

    // R1 R2 R9 R11: static modes per LED, both polarities, all input combos
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 10; m++) begin
        fw = '0; dw = '0;
        for (int n = 0; n < NL; n++) begin
          fw[4*n +: 4] = static_mode((m + n) % 10);
          dw[4*n+2] = ((n + p) % 2) == 0;
        end
        wr(1'b0, fw);
        wr(1'b1, dw);
        for (int s = 0; s < 64; s++) begin
          @(negedge clk);
          {rx_pulse, tx_pulse, link_lost, full_dup, speed_10m, link_up} = 6'(s);
          @(negedge clk);
          for (int n = 0; n < NL; n++) begin
            logic e;
            e = expect_static(fw[4*n +: 4], 6'(s));
            if (!dw[4*n+2]) e = ~e;
            check("R1 R2 R9 R11 static mode", led_o[n], e);
          end
        end
      end
    end
    @(negedge clk);
    {rx_pulse, tx_pulse, link_lost, full_dup, speed_10m, link_up} = 6'b000001;

    // R8 R9: override per LED
    wr(1'b0, 16'h0000);
    for (int n = 0; n < NL; n++)
      for (int v = 0; v < 2; v++)
        for (int p = 0; p < 2; p++) begin
          dw = 16'h4444;
          dw[4*n] = 1'b1; dw[4*n+1] = v[0]; dw[4*n+2] = p[0];
          wr(1'b1, dw);
          @(negedge clk);
          check("R8 R9 override level", led_o[n], (v == p) ? 1 : 0);
        end
    wr(1'b1, 16'h4444);

    // R7 R4: single stretch
    wr(1'b0, 16'h000E);
    @(negedge clk); xmii_err = 1;
    cnt = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (led_o[0]) cnt++;
      xmii_err = 0;
    end
    check("R4 R7 stretch length", cnt, STR);
    // R4: retrigger restarts
    @(negedge clk); xmii_err = 1;
    cnt = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (led_o[0]) cnt++;
      xmii_err = (c == 3);
    end
    check("R4 retrigger length", cnt, STR + 3);

    // R6: PRBS toggle
    wr(1'b0, 16'h000D);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk); prbs_err = 1;
      @(negedge clk); prbs_err = 0;
      @(negedge clk);
      check("R6 prbs toggle", led_o[0], k % 2);
    end

    // R3 R5: blink modes, TX activity only
    wr(1'b0, 16'h8BA9);
    for (int n = 0; n < NL; n++) tr[n] = 0;
    for (int c = 0; c < 70; c++) begin
      @(negedge clk);
      if (c >= 6) begin
        for (int n = 0; n < NL; n++) if (led_o[n] != prev[n]) tr[n]++;
      end
      prev = led_o;
      tx_pulse = (c % 3) == 0;
    end
    check("R3 any-activity blinks", (tr[0] >= 15 && tr[0] <= 17) ? 1 : 0, 1);
    check("R3 tx blinks", (tr[1] >= 15 && tr[1] <= 17) ? 1 : 0, 1);
    check("R3 rx ignores tx", tr[2], 0);
    check("R5 link blink", (tr[3] >= 15 && tr[3] <= 17) ? 1 : 0, 1);
    tx_pulse = 0;
    repeat (STR + 3) @(negedge clk);
    check("R3 blink stops", led_o[2:0], 0);
    check("R5 link steady after activity", led_o[3], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule